// File: doc/BRIEF.md
# Secure Exit State-Save Sequencer

When an interrupt, exception, VM exit or system-management interrupt forces execution out of a protected enclave, this block stores the interrupted register state into a save-area frame. It writes one word per cycle through a word-wide memory write port with a valid/ready handshake. It then presents a sanitized register image to the core, so that the code outside the enclave sees an opaque view of the enclave state.

All request inputs are captured on the cycle the request is accepted. These inputs are the event class, the REP-intermediate indicator, the two mode bits, the register file, the instruction pointer, the flags, the faulting address, the trap flag captured at entry and the debug opt-in flag. Later changes on the inputs do not affect the save in progress.

The frame layout depends on the execution mode. The saved copy and the synthetic copy of the resume flag and the trap flag follow separate rules, keyed on the event class and on REP progress.

The control is a five-state machine:
- IDLE waits for a request.
- SAVE_GPR writes the general registers.
- SAVE_IP writes the instruction pointer.
- SAVE_FLAGS writes the saved flags.
- DONE is a single cycle that raises `done`.

Its transitions are:
- IDLE to SAVE_GPR when a request is accepted.
- SAVE_GPR to SAVE_IP when the last register word is accepted.
- SAVE_IP to SAVE_FLAGS when the IP word is accepted.
- SAVE_FLAGS to DONE when the flags word is accepted.
- DONE to IDLE unconditionally.

Top module: `exit_save_seq`

## Requirements
- R1: The run is in 64-bit mode only when `lma` and `cs_l` are both 1 at acceptance; otherwise it is in 32-bit mode. A 64-bit run writes 18 words and a 32-bit run writes 10 words.
- R2: Write k goes to address k. Addresses 0..N-1 carry registers 0..N-1, where register i is `gpr_flat[64*i +: 64]`, N is 16 in 64-bit mode and N is 8 in 32-bit mode. Address N carries the instruction pointer and address N+1 carries the saved flags.
- R3: In 32-bit mode every written word holds only the low 32 bits of its source, with bits 63:32 equal to zero.
- R4: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold steady. Exactly one word advances per cycle in which both are 1.
- R5: `done` is 1 for exactly one cycle, the cycle after the flags word is accepted. `busy` is 1 from the cycle after acceptance through the `done` cycle.
- R6: `syn_valid` rises in the same cycle as `done` and stays 1 until the next accepted request. Until then `syn_rflags` and `syn_fault_addr` read zero. `syn_gpr_flat` is always zero.
- R7: The saved resume flag (bit 16) is forced to 1 for page faults (class 3) and other faults (class 4). For all other classes it keeps its live value: interrupt 0, trap 1, code breakpoint 2, VM exit 5, SMI 6.
- R8: When `rep_mid` is 1, the saved resume flag is 1 for every class.
- R9: The saved trap flag (bit 8) is 0. The synthetic resume flag (bit 16 of `syn_rflags`) is 0.
- R10: The synthetic trap flag is `entry_tf` when `dbg_optin` is 0, and the live trap flag when `dbg_optin` is 1. All other synthetic flag bits equal the captured flags.
- R11: For a page fault, `syn_fault_addr` is the captured faulting address with bits 11:0 cleared. For any other class it is the captured address unchanged.
- R12: A request arriving while `busy` is 1, including during the `done` cycle, is ignored. No new save starts, and the save in progress keeps its captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exit request, accepted when idle |
| evt_class | input | 3 | Event class code (see R7) |
| rep_mid | input | 1 | Event hit an intermediate REP iteration |
| lma | input | 1 | Long-mode-active bit |
| cs_l | input | 1 | Code-segment L bit |
| entry_tf | input | 1 | Trap flag captured at the most recent entry |
| dbg_optin | input | 1 | Most recent entry was a debug opt-in entry |
| gpr_flat | input | NUM_GPR*XLEN | Live general registers, register i at [XLEN*i +: XLEN] |
| rip | input | XLEN | Live instruction pointer |
| rflags | input | XLEN | Live flags |
| fault_addr | input | XLEN | Live faulting-address register |
| wr_ready | input | 1 | Save memory accepts the word |
| wr_valid | output | 1 | Save word valid |
| wr_addr | output | ADDR_W | Save word address |
| wr_data | output | XLEN | Save word data |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Save sequence in progress |
| syn_valid | output | 1 | Synthetic image is presented |
| syn_gpr_flat | output | NUM_GPR*XLEN | Synthetic registers (zero) |
| syn_rflags | output | XLEN | Synthetic flags |
| syn_fault_addr | output | XLEN | Synthetic faulting address |

## Verification
The hardest situations to reach from the ports are a request landing in the middle of a stalled save, or in the single `done` cycle. In either case the captured context must win over live inputs that have since changed. The bench scrambles every live input right after acceptance and drives `wr_ready` with random stalls. On selected runs it pulses `req_valid` mid-frame and again during `done`, then confirms that no new frame starts. Directed sweeps cover every event class in all four mode-bit combinations, and alternate `rep_mid` so that an exempt class still has its resume flag forced.

// File: rtl/exit_save_pkg.sv
package exit_save_pkg;

    localparam int FLAG_TF_BIT   = 8;
    localparam int FLAG_RF_BIT   = 16;
    localparam int PAGE_OFS_BITS = 12;
    localparam int CLASS_W       = 3;

    typedef enum logic [CLASS_W-1:0] {
        EV_INTR       = 3'd0,
        EV_TRAP       = 3'd1,
        EV_CODE_BP    = 3'd2,
        EV_PAGE_FAULT = 3'd3,
        EV_FAULT      = 3'd4,
        EV_VMEXIT     = 3'd5,
        EV_SMI        = 3'd6,
        EV_RSVD       = 3'd7
    } evt_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_GPR,
        ST_SAVE_IP,
        ST_SAVE_FLAGS,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        evt_class_e cls;
        logic       rep_mid;
        logic       mode64;
        logic       entry_tf;
        logic       dbg_optin;
    } exit_ctl_t;

endpackage

// File: rtl/exit_synth_calc.sv
module exit_synth_calc
    import exit_save_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  evt_class_e      cls,
    input  logic            rep_mid,
    input  logic            entry_tf,
    input  logic            dbg_optin,
    input  logic [XLEN-1:0] live_flags,
    input  logic [XLEN-1:0] fault_in,
    output logic [XLEN-1:0] save_flags,
    output logic [XLEN-1:0] syn_flags,
    output logic [XLEN-1:0] syn_fault
);

    logic class_forces_rf;

    // Faults other than the exempt kinds report resume = 1 in the frame
    always_comb begin
        unique case (cls)
            EV_PAGE_FAULT, EV_FAULT: class_forces_rf = 1'b1;
            default:                 class_forces_rf = 1'b0;
        endcase
    end

    always_comb begin
        save_flags              = live_flags;
        save_flags[FLAG_TF_BIT] = 1'b0;
        save_flags[FLAG_RF_BIT] = live_flags[FLAG_RF_BIT] | class_forces_rf | rep_mid;

        syn_flags               = live_flags;
        syn_flags[FLAG_RF_BIT]  = 1'b0;
        syn_flags[FLAG_TF_BIT]  = dbg_optin ? live_flags[FLAG_TF_BIT] : entry_tf;
    end

    always_comb begin
        syn_fault = fault_in;
        if (cls == EV_PAGE_FAULT) begin
            syn_fault[PAGE_OFS_BITS-1:0] = '0;
        end
    end

endmodule

// File: rtl/exit_word_sel.sv
module exit_word_sel
    import exit_save_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int NUM_GPR = 16,
    parameter int ADDR_W  = 5
) (
    input  seq_state_e              state,
    input  logic [ADDR_W-1:0]       idx,
    input  logic                    mode64,
    input  logic [NUM_GPR*XLEN-1:0] gpr_flat,
    input  logic [XLEN-1:0]         ip,
    input  logic [XLEN-1:0]         save_flags,
    output logic [XLEN-1:0]         word
);

    localparam int GIDX_W = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1;
    localparam int LOW_W  = XLEN / 2;

    logic [XLEN-1:0] gpr_arr [NUM_GPR];
    logic [XLEN-1:0] raw;

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_split
        assign gpr_arr[g] = gpr_flat[g*XLEN +: XLEN];
    end

    always_comb begin
        raw = '0;
        unique case (state)
            ST_SAVE_GPR: begin
                if (int'(idx) < NUM_GPR) begin
                    raw = gpr_arr[idx[GIDX_W-1:0]];
                end
            end
            ST_SAVE_IP:    raw = ip;
            ST_SAVE_FLAGS: raw = save_flags;
            default:       raw = '0;
        endcase
    end

    assign word = mode64 ? raw : {{(XLEN-LOW_W){1'b0}}, raw[LOW_W-1:0]};

endmodule

// File: rtl/exit_seq_fsm.sv
module exit_seq_fsm
    import exit_save_pkg::*;
#(
    parameter int NUM_GPR    = 16,
    parameter int LEGACY_GPR = 8,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              mode64,
    input  logic              wr_ready,
    output logic              start_o,
    output seq_state_e        state_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              last_accept_o
);

    localparam logic [ADDR_W-1:0] LAST_GPR_64 = ADDR_W'(NUM_GPR - 1);
    localparam logic [ADDR_W-1:0] LAST_GPR_32 = ADDR_W'(LEGACY_GPR - 1);
    localparam logic [ADDR_W:0]   WORDS_64    = (ADDR_W+1)'(NUM_GPR + 2);
    localparam logic [ADDR_W:0]   WORDS_32    = (ADDR_W+1)'(LEGACY_GPR + 2);

    seq_state_e        state, state_nx;
    logic [ADDR_W-1:0] widx;
    logic              accept;
    logic [ADDR_W-1:0] last_gpr;

    assign last_gpr = mode64 ? LAST_GPR_64 : LAST_GPR_32;
    assign accept   = wr_valid_o && wr_ready;
    assign start_o  = req_valid && (state == ST_IDLE);

    // State register and word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            widx  <= '0;
        end else begin
            state <= state_nx;
            if (start_o) begin
                widx <= '0;
            end else if (accept) begin
                widx <= widx + 1'b1;
            end
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = ST_SAVE_GPR;
            ST_SAVE_GPR:   if (accept && widx == last_gpr) state_nx = ST_SAVE_IP;
            ST_SAVE_IP:    if (accept) state_nx = ST_SAVE_FLAGS;
            ST_SAVE_FLAGS: if (accept) state_nx = ST_DONE;
            ST_DONE:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        wr_valid_o    = 1'b0;
        done_o        = 1'b0;
        busy_o        = 1'b1;
        unique case (state)
            ST_IDLE:       busy_o = 1'b0;
            ST_SAVE_GPR,
            ST_SAVE_IP,
            ST_SAVE_FLAGS: wr_valid_o = 1'b1;
            ST_DONE:       done_o = 1'b1;
            default:       busy_o = 1'b0;
        endcase
        last_accept_o = accept && (state == ST_SAVE_FLAGS);
    end

    assign state_o   = state;
    assign wr_addr_o = widx;

    // Checker: words accepted in the current run
    logic [ADDR_W:0] acc_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (start_o) begin
            acc_cnt <= '0;
        end else if (accept) begin
            acc_cnt <= acc_cnt + 1'b1;
        end
    end

    assert_word_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> acc_cnt == (mode64 ? WORDS_64 : WORDS_32));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready) |=> (wr_valid_o && $stable(wr_addr_o)));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state != ST_SAVE_FLAGS) |=> wr_addr_o == $past(wr_addr_o) + 1'b1);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(accept));

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_valid && state != ST_DONE) |=> state != ST_IDLE);

endmodule

// File: rtl/exit_save_seq.sv
module exit_save_seq
    import exit_save_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int NUM_GPR    = 16,
    parameter int LEGACY_GPR = 8,
    parameter int ADDR_W     = $clog2(NUM_GPR + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [CLASS_W-1:0]      evt_class,
    input  logic                    rep_mid,
    input  logic                    lma,
    input  logic                    cs_l,
    input  logic                    entry_tf,
    input  logic                    dbg_optin,
    input  logic [NUM_GPR*XLEN-1:0] gpr_flat,
    input  logic [XLEN-1:0]         rip,
    input  logic [XLEN-1:0]         rflags,
    input  logic [XLEN-1:0]         fault_addr,
    input  logic                    wr_ready,
    output logic                    wr_valid,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [XLEN-1:0]         wr_data,
    output logic                    done,
    output logic                    busy,
    output logic                    syn_valid,
    output logic [NUM_GPR*XLEN-1:0] syn_gpr_flat,
    output logic [XLEN-1:0]         syn_rflags,
    output logic [XLEN-1:0]         syn_fault_addr
);

    localparam int HI_W = XLEN / 2;

    exit_ctl_t               ctl;
    logic [NUM_GPR*XLEN-1:0] snap_gpr;
    logic [XLEN-1:0]         snap_ip, snap_flags, snap_fault;
    logic                    start, last_accept;
    seq_state_e              state;
    logic [XLEN-1:0]         save_flags, syn_flags_c, syn_fault_c;
    logic                    syn_valid_q;

    exit_seq_fsm #(
        .NUM_GPR    (NUM_GPR),
        .LEGACY_GPR (LEGACY_GPR),
        .ADDR_W     (ADDR_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mode64        (ctl.mode64),
        .wr_ready      (wr_ready),
        .start_o       (start),
        .state_o       (state),
        .wr_valid_o    (wr_valid),
        .wr_addr_o     (wr_addr),
        .done_o        (done),
        .busy_o        (busy),
        .last_accept_o (last_accept)
    );

    // Context capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl        <= '0;
            snap_gpr   <= '0;
            snap_ip    <= '0;
            snap_flags <= '0;
            snap_fault <= '0;
        end else if (start) begin
            ctl.cls       <= evt_class_e'(evt_class);
            ctl.rep_mid   <= rep_mid;
            ctl.mode64    <= lma && cs_l;
            ctl.entry_tf  <= entry_tf;
            ctl.dbg_optin <= dbg_optin;
            snap_gpr      <= gpr_flat;
            snap_ip       <= rip;
            snap_flags    <= rflags;
            snap_fault    <= fault_addr;
        end
    end

    exit_synth_calc #(.XLEN(XLEN)) calc_i (
        .cls        (ctl.cls),
        .rep_mid    (ctl.rep_mid),
        .entry_tf   (ctl.entry_tf),
        .dbg_optin  (ctl.dbg_optin),
        .live_flags (snap_flags),
        .fault_in   (snap_fault),
        .save_flags (save_flags),
        .syn_flags  (syn_flags_c),
        .syn_fault  (syn_fault_c)
    );

    exit_word_sel #(
        .XLEN    (XLEN),
        .NUM_GPR (NUM_GPR),
        .ADDR_W  (ADDR_W)
    ) sel_i (
        .state      (state),
        .idx        (wr_addr),
        .mode64     (ctl.mode64),
        .gpr_flat   (snap_gpr),
        .ip         (snap_ip),
        .save_flags (save_flags),
        .word       (wr_data)
    );

    // Synthetic image presented once the frame is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_valid_q <= 1'b0;
        end else if (start) begin
            syn_valid_q <= 1'b0;
        end else if (last_accept) begin
            syn_valid_q <= 1'b1;
        end
    end

    assign syn_valid      = syn_valid_q;
    assign syn_gpr_flat   = '0;
    assign syn_rflags     = syn_valid_q ? syn_flags_c : '0;
    assign syn_fault_addr = syn_valid_q ? syn_fault_c : '0;

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(wr_data));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !ctl.mode64) |-> wr_data[XLEN-1:HI_W] == '0);

    assert_saved_tf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && state == ST_SAVE_FLAGS) |-> !wr_data[FLAG_TF_BIT]);

    assert_rep_rf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && state == ST_SAVE_FLAGS && ctl.rep_mid) |-> wr_data[FLAG_RF_BIT]);

    assert_fault_rf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && state == ST_SAVE_FLAGS &&
         (ctl.cls == EV_PAGE_FAULT || ctl.cls == EV_FAULT)) |-> wr_data[FLAG_RF_BIT]);

    assert_syn_rf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        syn_valid |-> !syn_rflags[FLAG_RF_BIT]);

    assert_syn_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syn_valid) |-> done);

    assert_syn_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_valid && ctl.cls == EV_PAGE_FAULT) |-> syn_fault_addr[PAGE_OFS_BITS-1:0] == '0);

endmodule

// File: tb/exit_save_seq_tb.sv
module exit_save_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int XL = 64;
    localparam int NG = 16;
    localparam int AW = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic [2:0]      evt_class;
    logic            rep_mid, lma, cs_l, entry_tf, dbg_optin;
    logic [NG*XL-1:0] gpr_flat;
    logic [XL-1:0]   rip, rflags, fault_addr;
    logic            wr_ready;
    logic            wr_valid;
    logic [AW-1:0]   wr_addr;
    logic [XL-1:0]   wr_data;
    logic            done, busy, syn_valid;
    logic [NG*XL-1:0] syn_gpr_flat;
    logic [XL-1:0]   syn_rflags, syn_fault_addr;

    int checks = 0;
    int errors = 0;

    exit_save_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .evt_class(evt_class),
        .rep_mid(rep_mid), .lma(lma), .cs_l(cs_l), .entry_tf(entry_tf),
        .dbg_optin(dbg_optin), .gpr_flat(gpr_flat), .rip(rip), .rflags(rflags),
        .fault_addr(fault_addr), .wr_ready(wr_ready), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .busy(busy),
        .syn_valid(syn_valid), .syn_gpr_flat(syn_gpr_flat),
        .syn_rflags(syn_rflags), .syn_fault_addr(syn_fault_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [XL-1:0] act, input logic [XL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [XL-1:0] f_saved_flags(logic [XL-1:0] fl, logic [2:0] c, logic rep);
        logic [XL-1:0] r = fl;
        r[8] = 1'b0;
        if (rep || c == 3'd3 || c == 3'd4) r[16] = 1'b1;
        return r;
    endfunction

    function automatic logic [XL-1:0] f_syn_flags(logic [XL-1:0] fl, logic etf, logic dbg);
        logic [XL-1:0] r = fl;
        r[16] = 1'b0;
        r[8]  = dbg ? fl[8] : etf;
        return r;
    endfunction

    function automatic logic [XL-1:0] f_fault(logic [XL-1:0] a, logic [2:0] c);
        logic [XL-1:0] r = a;
        if (c == 3'd3) r[11:0] = '0;
        return r;
    endfunction

    function automatic logic [XL-1:0] f_word(int k, logic m64, logic [NG*XL-1:0] g,
                                             logic [XL-1:0] ip, logic [XL-1:0] sfl);
        int n = m64 ? 16 : 8;
        logic [XL-1:0] w;
        if (k < n)       w = g[XL*k +: XL];
        else if (k == n) w = ip;
        else             w = sfl;
        return m64 ? w : {32'b0, w[31:0]};
    endfunction

    task automatic scramble();
        for (int i = 0; i < NG; i++) gpr_flat[XL*i +: XL] = {$urandom, $urandom};
        rip        = {$urandom, $urandom};
        rflags     = {$urandom, $urandom};
        fault_addr = {$urandom, $urandom};
        evt_class  = 3'($urandom % 7);
        rep_mid    = 1'($urandom);
        lma        = 1'($urandom);
        cs_l       = 1'($urandom);
        entry_tf   = 1'($urandom);
        dbg_optin  = 1'($urandom);
    endtask

    // Called at a negedge with the inputs of the exit already driven
    task automatic run_exit(input bit poke);
        logic [2:0]       c_cls = evt_class;
        logic             c_rep = rep_mid;
        logic             c_m64 = lma && cs_l;
        logic [NG*XL-1:0] c_gpr = gpr_flat;
        logic [XL-1:0]    c_ip  = rip;
        logic [XL-1:0]    c_fl  = rflags;
        logic             c_etf = entry_tf;
        logic             c_dbg = dbg_optin;
        logic [XL-1:0]    c_fa  = fault_addr;
        logic [XL-1:0]    sfl;
        logic [XL-1:0]    syn_exp;
        int n, k;
        bit rdy;
        sfl = f_saved_flags(c_fl, c_cls, c_rep);
        n = (c_m64 ? 16 : 8) + 2;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        scramble();
        check(syn_valid == 1'b0 && syn_rflags == '0 && syn_fault_addr == '0,
              "R6", "syn hidden during save", syn_rflags, '0);
        check(busy == 1'b1, "R5", "busy after accept", XL'(busy), 1);
        k = 0;
        while (k < n) begin
            check(wr_valid == 1'b1, "R4", "wr_valid held", XL'(wr_valid), 1);
            check(wr_addr == AW'(k), "R2", "address order", XL'(wr_addr), XL'(k));
            check(wr_data == f_word(k, c_m64, c_gpr, c_ip, sfl), c_m64 ? "R2" : "R3",
                  "word data", wr_data, f_word(k, c_m64, c_gpr, c_ip, sfl));
            check(done == 1'b0, "R5", "no early done", XL'(done), 0);
            if (k == n - 1) begin
                check(wr_data[16] == sfl[16], c_rep ? "R8" : "R7", "saved RF",
                      XL'(wr_data[16]), XL'(sfl[16]));
                check(wr_data[8] == 1'b0, "R9", "saved TF", XL'(wr_data[8]), 0);
            end
            if (poke && k == 3) req_valid = 1'b1;
            rdy = ($urandom % 3) != 0;
            wr_ready = rdy;
            @(negedge clk);
            req_valid = 1'b0;
            if (rdy) k++;
        end
        wr_ready = 1'b0;
        check(done == 1'b1, "R1", "done after frame length", XL'(done), 1);
        check(wr_valid == 1'b0, "R5", "no write in done", XL'(wr_valid), 0);
        check(syn_valid == 1'b1, "R6", "syn_valid with done", XL'(syn_valid), 1);
        check(syn_gpr_flat == '0, "R6", "syn gprs zero", syn_gpr_flat[XL-1:0], '0);
        syn_exp = f_syn_flags(c_fl, c_etf, c_dbg);
        check(syn_rflags == syn_exp, "R10", "syn flags", syn_rflags, syn_exp);
        check(syn_rflags[16] == 1'b0, "R9", "syn RF", XL'(syn_rflags[16]), 0);
        check(syn_fault_addr == f_fault(c_fa, c_cls), "R11", "syn fault addr",
              syn_fault_addr, f_fault(c_fa, c_cls));
        if (poke) req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(done == 1'b0 && busy == 1'b0, "R5", "done one cycle", XL'({done, busy}), 0);
        if (poke) begin
            @(negedge clk);
            check(wr_valid == 1'b0 && busy == 1'b0, "R12", "ignored request",
                  XL'({wr_valid, busy}), 0);
            check(syn_valid == 1'b1 && syn_rflags == syn_exp, "R6", "syn held",
                  syn_rflags, syn_exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0;
        req_valid = 1'b0;
        wr_ready = 1'b0;
        scramble();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_valid == 0 && done == 0 && busy == 0 && syn_valid == 0 && syn_rflags == '0,
              "R6", "reset state", XL'({wr_valid, done, busy, syn_valid}), 0);
        for (int c = 0; c < 7; c++) begin
            for (int m = 0; m < 4; m++) begin
                scramble();
                evt_class = 3'(c);
                lma       = 1'(m >> 1);
                cs_l      = 1'(m);
                rep_mid   = 1'((c + m) % 2);
                dbg_optin = 1'(m % 2);
                run_exit(c == 3 || m == 2);
            end
        end
        for (int i = 0; i < 40; i++) begin
            scramble();
            run_exit(($urandom % 4) == 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule